// File: doc/BRIEF.md
# Snooping Cache Line Coherence Controller (five-state, forwarding sharer)

This block holds the coherence state of every line in one cache of a snooping multiprocessor and decides, for each event, how that state moves. The processor side presents a read or write to one line index. The bus side presents a snooped request from another cache to one line index, together with a wired-OR indication of whether any other cache holds the block. Each line is in one of five states: invalid, shared (read-only, any number of holders), forward (the one sharer that sources data for the next reader), exclusive (the only copy, clean) and modified (the only copy, dirty). The exclusive state lets a local write proceed with no bus traffic. The forward state lets a cache, and not memory, answer a read of a shared block.

For a processor event the block returns the bus request this cache must issue. For a snoop it returns whether this cache supplies the data, whether it must write the block back, and whether it holds a copy. State updates take effect at the next clock edge. Data arrays, bus arbitration and memory are outside the block. A query port reads the state of any line without side effects.

Top module: `mesif_line_ctrl`

## Requirements
- R1: After reset every line reads back through the query port as invalid. The state codes are invalid=0, shared=1, exclusive=2, forward=3, modified=4.
- R2: A processor read to an invalid line drives `bus_req`=1 (read) in that cycle. The line becomes exclusive if `shared_in` is low in that cycle, and forward if it is high.
- R3: A processor read to a valid line issues no request (`bus_req`=0) and leaves the state unchanged.
- R4: A processor write leaves the line modified. From exclusive or modified it issues no request. From shared or forward it issues `bus_req`=3 (upgrade/invalidate). From invalid it issues `bus_req`=2 (read-for-ownership).
- R5: A snooped read (`snp_kind`=0) to a valid line raises `shared_out` and leaves the line shared. From modified it raises `supply_data` and `write_back`. From forward it raises `supply_data` only. From shared or exclusive it raises neither. A snooped read to an invalid line raises nothing.
- R6: A snooped read-for-ownership (`snp_kind`=1) leaves any line invalid. It raises `supply_data` from modified or forward, and `write_back` from modified only. It does not raise `shared_out`.
- R7: A snooped invalidate (`snp_kind`=2) leaves any line invalid. It raises `supply_data` and `write_back` only if the line was modified.
- R8: If a processor event and a non-reserved snoop target the same index in one cycle, the snoop is applied, `cpu_retry` is high, `bus_req` is 0, and the processor event has no effect.
- R9: A snoop with `snp_kind`=3 is reserved. It raises no output and changes no line.
- R10: An event on one index leaves every other line unchanged, and a processor event and a snoop on different indices in one cycle are both applied.
- R11: In a group of controllers whose snoops are the other members' bus requests (read to 0, read-for-ownership to 1, upgrade to 2), each block has at most one holder in exclusive, forward or modified, and a modified holder coexists with no other valid copy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_valid | input | 1 | Processor event present |
| cpu_write | input | 1 | Processor event is a write (else a read) |
| cpu_idx | input | IDX_W | Line index of the processor event |
| shared_in | input | 1 | Another cache holds the block (sampled on read miss) |
| snp_valid | input | 1 | Snooped bus request present |
| snp_kind | input | 2 | 0 read, 1 read-for-ownership, 2 invalidate, 3 reserved |
| snp_idx | input | IDX_W | Line index of the snoop |
| qry_idx | input | IDX_W | Line index to read back |
| bus_req | output | 2 | 0 none, 1 read, 2 read-for-ownership, 3 upgrade |
| cpu_retry | output | 1 | Processor event dropped by a same-line snoop |
| supply_data | output | 1 | This cache sources the snooped block |
| write_back | output | 1 | This cache writes the block to memory |
| shared_out | output | 1 | This cache holds the block being read |
| qry_state | output | 3 | State code of line `qry_idx` |

## Verification
The hardest situation to reach from the ports is the group rule of R11. It needs several caches to pass one block among themselves through every holder pattern: a dirty owner hit by a reader, a forwarder displaced by a new reader, a sharer upgrading past a forwarder. A single controller cannot show any of this. The bench therefore runs three controllers as one coherence group. It routes each chosen requester's expected bus request as a snoop to the other two, and drives `shared_in` from whether those peers hold the block. After every step it reads all three states of the touched line through the query ports and checks the ownership rule on them. A directed vector table first walks one controller through each transition, the same-line collision and the reserved snoop code.

// File: rtl/mesif_pkg.sv
package mesif_pkg;

  typedef enum logic [2:0] {
    ST_I = 3'd0,
    ST_S = 3'd1,
    ST_E = 3'd2,
    ST_F = 3'd3,
    ST_M = 3'd4
  } line_state_t;

  typedef enum logic [1:0] {
    REQ_NONE = 2'd0,
    REQ_READ = 2'd1,
    REQ_RFO  = 2'd2,
    REQ_UPGR = 2'd3
  } bus_req_t;

  typedef enum logic [1:0] {
    SNP_READ = 2'd0,
    SNP_RFO  = 2'd1,
    SNP_INV  = 2'd2,
    SNP_RSVD = 2'd3
  } snp_kind_t;

  typedef struct packed {
    line_state_t nxt;
    bus_req_t    req;
  } cpu_res_t;

  typedef struct packed {
    line_state_t nxt;
    logic        act;
    logic        supply;
    logic        wb;
    logic        shared_hit;
  } snp_res_t;

  function automatic logic holds_copy(line_state_t s);
    return s != ST_I;
  endfunction

  function automatic logic is_owner(line_state_t s);
    return (s == ST_E) || (s == ST_F) || (s == ST_M);
  endfunction

  // Local processor event: next state and the bus request it needs.
  function automatic cpu_res_t cpu_step(line_state_t cur, logic wr, logic shared_in);
    cpu_res_t r;
    r.nxt = cur;
    r.req = REQ_NONE;
    case (cur)
      ST_I: begin
        if (wr) begin
          r.nxt = ST_M;
          r.req = REQ_RFO;
        end else begin
          r.nxt = shared_in ? ST_F : ST_E;
          r.req = REQ_READ;
        end
      end
      ST_S, ST_F: begin
        if (wr) begin
          r.nxt = ST_M;
          r.req = REQ_UPGR;
        end
      end
      ST_E: begin
        if (wr) r.nxt = ST_M;
      end
      ST_M: r.nxt = ST_M;
      default: begin
        r.nxt = ST_I;
        r.req = REQ_NONE;
      end
    endcase
    return r;
  endfunction

  // Snooped remote request: next state and this cache's response.
  function automatic snp_res_t snp_step(line_state_t cur, snp_kind_t k);
    snp_res_t r;
    r.nxt        = cur;
    r.act        = 1'b0;
    r.supply     = 1'b0;
    r.wb         = 1'b0;
    r.shared_hit = 1'b0;
    if (holds_copy(cur) && (k != SNP_RSVD)) begin
      r.act = 1'b1;
      r.wb  = (cur == ST_M);
      case (k)
        SNP_READ: begin
          r.nxt        = ST_S;
          r.shared_hit = 1'b1;
          r.supply     = (cur == ST_M) || (cur == ST_F);
        end
        SNP_RFO: begin
          r.nxt    = ST_I;
          r.supply = (cur == ST_M) || (cur == ST_F);
        end
        default: begin
          r.nxt    = ST_I;
          r.supply = (cur == ST_M);
        end
      endcase
    end
    return r;
  endfunction

endpackage

// File: rtl/mesif_state_array.sv
module mesif_state_array
  import mesif_pkg::*;
#(
  parameter int NUM_LINES = 8,
  parameter int IDX_W     = $clog2(NUM_LINES)
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          cpu_we,
  input  logic [IDX_W-1:0]              cpu_idx,
  input  line_state_t                   cpu_nxt,
  input  logic                          snp_we,
  input  logic [IDX_W-1:0]              snp_idx,
  input  line_state_t                   snp_nxt,
  output line_state_t [NUM_LINES-1:0]   states
);

  for (genvar i = 0; i < NUM_LINES; i++) begin : g_line
    logic hit_snp;
    logic hit_cpu;

    assign hit_snp = snp_we && (snp_idx == IDX_W'(i));
    assign hit_cpu = cpu_we && (cpu_idx == IDX_W'(i));

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        states[i] <= ST_I;
      end else if (hit_snp) begin
        states[i] <= snp_nxt;
      end else if (hit_cpu) begin
        states[i] <= cpu_nxt;
      end
    end
  end

endmodule

// File: rtl/mesif_cpu_path.sv
module mesif_cpu_path
  import mesif_pkg::*;
(
  input  logic        ev_valid,
  input  logic        ev_write,
  input  logic        shared_in,
  input  logic        collide,
  input  line_state_t cur,
  output logic        upd,
  output line_state_t nxt,
  output bus_req_t    req,
  output logic        retry
);

  cpu_res_t res;

  always_comb begin
    res   = cpu_step(cur, ev_write, shared_in);
    retry = ev_valid && collide;
    upd   = ev_valid && !collide;
    nxt   = res.nxt;
    req   = upd ? res.req : REQ_NONE;
  end

endmodule

// File: rtl/mesif_snoop_path.sv
module mesif_snoop_path
  import mesif_pkg::*;
(
  input  logic        ev_valid,
  input  logic [1:0]  kind,
  input  line_state_t cur,
  output logic        upd,
  output line_state_t nxt,
  output logic        supply,
  output logic        wb,
  output logic        shared_hit
);

  snp_res_t res;

  always_comb begin
    res        = snp_step(cur, snp_kind_t'(kind));
    upd        = ev_valid && res.act;
    nxt        = res.nxt;
    supply     = ev_valid && res.supply;
    wb         = ev_valid && res.wb;
    shared_hit = ev_valid && res.shared_hit;
  end

endmodule

// File: rtl/mesif_line_ctrl.sv
module mesif_line_ctrl
  import mesif_pkg::*;
#(
  parameter int NUM_LINES = 8,
  parameter int IDX_W     = $clog2(NUM_LINES)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cpu_valid,
  input  logic             cpu_write,
  input  logic [IDX_W-1:0] cpu_idx,
  input  logic             shared_in,
  input  logic             snp_valid,
  input  logic [1:0]       snp_kind,
  input  logic [IDX_W-1:0] snp_idx,
  input  logic [IDX_W-1:0] qry_idx,
  output logic [1:0]       bus_req,
  output logic             cpu_retry,
  output logic             supply_data,
  output logic             write_back,
  output logic             shared_out,
  output logic [2:0]       qry_state
);

  line_state_t [NUM_LINES-1:0] states;
  line_state_t                 cpu_cur;
  line_state_t                 snp_cur;
  line_state_t                 cpu_nxt;
  line_state_t                 snp_nxt;
  bus_req_t                    cpu_req;
  logic                        snp_live;
  logic                        collide;
  logic                        cpu_we;
  logic                        snp_we;

  assign cpu_cur  = states[cpu_idx];
  assign snp_cur  = states[snp_idx];
  assign snp_live = snp_valid && (snp_kind != SNP_RSVD);
  assign collide  = snp_live && cpu_valid && (cpu_idx == snp_idx);

  mesif_cpu_path u_cpu (
    .ev_valid  (cpu_valid),
    .ev_write  (cpu_write),
    .shared_in (shared_in),
    .collide   (collide),
    .cur       (cpu_cur),
    .upd       (cpu_we),
    .nxt       (cpu_nxt),
    .req       (cpu_req),
    .retry     (cpu_retry)
  );

  mesif_snoop_path u_snp (
    .ev_valid   (snp_valid),
    .kind       (snp_kind),
    .cur        (snp_cur),
    .upd        (snp_we),
    .nxt        (snp_nxt),
    .supply     (supply_data),
    .wb         (write_back),
    .shared_hit (shared_out)
  );

  mesif_state_array #(
    .NUM_LINES (NUM_LINES),
    .IDX_W     (IDX_W)
  ) u_arr (
    .clk     (clk),
    .rst_n   (rst_n),
    .cpu_we  (cpu_we),
    .cpu_idx (cpu_idx),
    .cpu_nxt (cpu_nxt),
    .snp_we  (snp_we),
    .snp_idx (snp_idx),
    .snp_nxt (snp_nxt),
    .states  (states)
  );

  assign bus_req   = cpu_req;
  assign qry_state = states[qry_idx];

endmodule

// File: rtl/mesif_line_ctrl_chk.sv
module mesif_line_ctrl_chk
  import mesif_pkg::*;
#(
  parameter int NUM_LINES = 8,
  parameter int IDX_W     = $clog2(NUM_LINES)
) (
  input logic                        clk,
  input logic                        rst_n,
  input logic                        cpu_valid,
  input logic                        cpu_write,
  input logic [IDX_W-1:0]            cpu_idx,
  input logic                        snp_valid,
  input logic [1:0]                  snp_kind,
  input logic [IDX_W-1:0]            snp_idx,
  input logic [1:0]                  bus_req,
  input logic                        cpu_retry,
  input logic                        supply_data,
  input logic                        write_back,
  input logic                        shared_out,
  input line_state_t [NUM_LINES-1:0] states,
  input line_state_t                 cpu_cur,
  input line_state_t                 snp_cur
);

  a_r2_miss_reads: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_valid && !cpu_write && !cpu_retry && (cpu_cur == ST_I) |-> bus_req == 2'd1);

  a_r3_hit_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_valid && !cpu_write && (cpu_cur != ST_I) |-> bus_req == 2'd0);

  a_r4_write_lands_m: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_valid && cpu_write && !cpu_retry |=> states[$past(cpu_idx)] == ST_M);

  a_r4_owner_write_silent: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_valid && cpu_write && ((cpu_cur == ST_E) || (cpu_cur == ST_M)) |-> bus_req == 2'd0);

  a_r5_wb_needs_supply: assert property (@(posedge clk) disable iff (!rst_n)
    write_back |-> supply_data && snp_valid);

  a_r5_read_leaves_shared: assert property (@(posedge clk) disable iff (!rst_n)
    snp_valid && (snp_kind == 2'd0) && (snp_cur != ST_I) |=> states[$past(snp_idx)] == ST_S);

  a_r6_kill_invalidates: assert property (@(posedge clk) disable iff (!rst_n)
    snp_valid && ((snp_kind == 2'd1) || (snp_kind == 2'd2)) |=> states[$past(snp_idx)] == ST_I);

  a_r8_retry_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_retry |-> cpu_valid && (bus_req == 2'd0));

  a_r9_reserved_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    snp_valid && (snp_kind == 2'd3) |-> !supply_data && !write_back && !shared_out);

  a_r9_reserved_keeps: assert property (@(posedge clk) disable iff (!rst_n)
    snp_valid && (snp_kind == 2'd3) && !cpu_valid |=> $stable(states));

endmodule

bind mesif_line_ctrl mesif_line_ctrl_chk #(
  .NUM_LINES (NUM_LINES),
  .IDX_W     (IDX_W)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .cpu_valid   (cpu_valid),
  .cpu_write   (cpu_write),
  .cpu_idx     (cpu_idx),
  .snp_valid   (snp_valid),
  .snp_kind    (snp_kind),
  .snp_idx     (snp_idx),
  .bus_req     (bus_req),
  .cpu_retry   (cpu_retry),
  .supply_data (supply_data),
  .write_back  (write_back),
  .shared_out  (shared_out),
  .states      (states),
  .cpu_cur     (cpu_cur),
  .snp_cur     (snp_cur)
);

// File: tb/tb_mesif_line_ctrl.sv
module tb_mesif_line_ctrl;

  localparam int LINES = 8;
  localparam int NC    = 3;
  localparam int ITERS = 600;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  logic       cv [NC];
  logic       cw [NC];
  logic [2:0] ci [NC];
  logic       sh [NC];
  logic       sv [NC];
  logic [1:0] sk [NC];
  logic [2:0] si [NC];
  logic [2:0] qi [NC];
  logic [1:0] breq [NC];
  logic       rty [NC];
  logic       sup [NC];
  logic       wbk [NC];
  logic       sho [NC];
  logic [2:0] qs [NC];

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;
  int mdl [NC][LINES];

  mesif_line_ctrl #(.NUM_LINES(LINES)) dut (
    .clk(clk), .rst_n(rst_n), .cpu_valid(cv[0]), .cpu_write(cw[0]), .cpu_idx(ci[0]),
    .shared_in(sh[0]), .snp_valid(sv[0]), .snp_kind(sk[0]), .snp_idx(si[0]), .qry_idx(qi[0]),
    .bus_req(breq[0]), .cpu_retry(rty[0]), .supply_data(sup[0]), .write_back(wbk[0]),
    .shared_out(sho[0]), .qry_state(qs[0]));

  mesif_line_ctrl #(.NUM_LINES(LINES)) peer1 (
    .clk(clk), .rst_n(rst_n), .cpu_valid(cv[1]), .cpu_write(cw[1]), .cpu_idx(ci[1]),
    .shared_in(sh[1]), .snp_valid(sv[1]), .snp_kind(sk[1]), .snp_idx(si[1]), .qry_idx(qi[1]),
    .bus_req(breq[1]), .cpu_retry(rty[1]), .supply_data(sup[1]), .write_back(wbk[1]),
    .shared_out(sho[1]), .qry_state(qs[1]));

  mesif_line_ctrl #(.NUM_LINES(LINES)) peer2 (
    .clk(clk), .rst_n(rst_n), .cpu_valid(cv[2]), .cpu_write(cw[2]), .cpu_idx(ci[2]),
    .shared_in(sh[2]), .snp_valid(sv[2]), .snp_kind(sk[2]), .snp_idx(si[2]), .qry_idx(qi[2]),
    .bus_req(breq[2]), .cpu_retry(rty[2]), .supply_data(sup[2]), .write_back(wbk[2]),
    .shared_out(sho[2]), .qry_state(qs[2]));

  // Directed vector: stimulus for dut, expected outputs, then the state
  // of line qi expected after the clock edge.
  typedef struct packed {
    logic [3:0] tag;
    logic       cv; logic cw; logic [2:0] ci;
    logic       sv; logic [1:0] sk; logic [2:0] si;
    logic       sh;
    logic [1:0] req; logic sup; logic wb; logic so; logic rt;
    logic [2:0] qi; logic [2:0] qs;
  } vec_t;

  localparam int NV = 24;
  localparam vec_t VECS [NV] = '{
    '{4'd2, 1'b1,1'b0,3'd0, 1'b0,2'd0,3'd0, 1'b0, 2'd1,1'b0,1'b0,1'b0,1'b0, 3'd0,3'd2}, // R2 miss alone
    '{4'd2, 1'b1,1'b0,3'd1, 1'b0,2'd0,3'd0, 1'b1, 2'd1,1'b0,1'b0,1'b0,1'b0, 3'd1,3'd3}, // R2 miss shared
    '{4'd3, 1'b1,1'b0,3'd0, 1'b0,2'd0,3'd0, 1'b0, 2'd0,1'b0,1'b0,1'b0,1'b0, 3'd0,3'd2}, // R3 hit E
    '{4'd4, 1'b1,1'b1,3'd0, 1'b0,2'd0,3'd0, 1'b0, 2'd0,1'b0,1'b0,1'b0,1'b0, 3'd0,3'd4}, // R4 E silent
    '{4'd4, 1'b1,1'b1,3'd1, 1'b0,2'd0,3'd0, 1'b0, 2'd3,1'b0,1'b0,1'b0,1'b0, 3'd1,3'd4}, // R4 F upgrade
    '{4'd4, 1'b1,1'b1,3'd2, 1'b0,2'd0,3'd0, 1'b0, 2'd2,1'b0,1'b0,1'b0,1'b0, 3'd2,3'd4}, // R4 I rfo
    '{4'd5, 1'b0,1'b0,3'd0, 1'b1,2'd0,3'd0, 1'b0, 2'd0,1'b1,1'b1,1'b1,1'b0, 3'd0,3'd1}, // R5 M read
    '{4'd3, 1'b1,1'b0,3'd0, 1'b0,2'd0,3'd0, 1'b0, 2'd0,1'b0,1'b0,1'b0,1'b0, 3'd0,3'd1}, // R3 hit S
    '{4'd9, 1'b0,1'b0,3'd0, 1'b1,2'd3,3'd2, 1'b0, 2'd0,1'b0,1'b0,1'b0,1'b0, 3'd2,3'd4}, // R9 reserved
    '{4'd6, 1'b0,1'b0,3'd0, 1'b1,2'd1,3'd2, 1'b0, 2'd0,1'b1,1'b1,1'b0,1'b0, 3'd2,3'd0}, // R6 M rfo
    '{4'd2, 1'b1,1'b0,3'd3, 1'b0,2'd0,3'd0, 1'b1, 2'd1,1'b0,1'b0,1'b0,1'b0, 3'd3,3'd3}, // R2 to F
    '{4'd5, 1'b0,1'b0,3'd0, 1'b1,2'd0,3'd3, 1'b0, 2'd0,1'b1,1'b0,1'b1,1'b0, 3'd3,3'd1}, // R5 F read
    '{4'd7, 1'b0,1'b0,3'd0, 1'b1,2'd2,3'd3, 1'b0, 2'd0,1'b0,1'b0,1'b0,1'b0, 3'd3,3'd0}, // R7 S inv
    '{4'd4, 1'b1,1'b1,3'd1, 1'b0,2'd0,3'd0, 1'b0, 2'd0,1'b0,1'b0,1'b0,1'b0, 3'd1,3'd4}, // R4 M silent
    '{4'd8, 1'b1,1'b1,3'd1, 1'b1,2'd0,3'd1, 1'b0, 2'd0,1'b1,1'b1,1'b1,1'b1, 3'd1,3'd1}, // R8 collision
    '{4'd6, 1'b0,1'b0,3'd0, 1'b1,2'd1,3'd0, 1'b0, 2'd0,1'b0,1'b0,1'b0,1'b0, 3'd0,3'd0}, // R6 S rfo
    '{4'd2, 1'b1,1'b0,3'd4, 1'b0,2'd0,3'd0, 1'b0, 2'd1,1'b0,1'b0,1'b0,1'b0, 3'd4,3'd2}, // R2 to E
    '{4'd5, 1'b0,1'b0,3'd0, 1'b1,2'd0,3'd4, 1'b0, 2'd0,1'b0,1'b0,1'b1,1'b0, 3'd4,3'd1}, // R5 E read
    '{4'd10,1'b1,1'b0,3'd5, 1'b1,2'd2,3'd4, 1'b0, 2'd1,1'b0,1'b0,1'b0,1'b0, 3'd5,3'd2}, // R10 both apply
    '{4'd10,1'b0,1'b0,3'd0, 1'b0,2'd0,3'd0, 1'b0, 2'd0,1'b0,1'b0,1'b0,1'b0, 3'd4,3'd0}, // R10 other line
    '{4'd5, 1'b0,1'b0,3'd0, 1'b1,2'd0,3'd6, 1'b0, 2'd0,1'b0,1'b0,1'b0,1'b0, 3'd6,3'd0}, // R5 I read
    '{4'd4, 1'b1,1'b1,3'd7, 1'b0,2'd0,3'd0, 1'b0, 2'd2,1'b0,1'b0,1'b0,1'b0, 3'd7,3'd4}, // R4 I rfo
    '{4'd7, 1'b0,1'b0,3'd0, 1'b1,2'd2,3'd7, 1'b0, 2'd0,1'b1,1'b1,1'b0,1'b0, 3'd7,3'd0}, // R7 M inv
    '{4'd10,1'b0,1'b0,3'd0, 1'b0,2'd0,3'd0, 1'b0, 2'd0,1'b0,1'b0,1'b0,1'b0, 3'd1,3'd1}  // R10 line1 kept
  };

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic idle_all();
    for (int k = 0; k < NC; k++) begin
      cv[k] = 1'b0; cw[k] = 1'b0; ci[k] = '0; sh[k] = 1'b0;
      sv[k] = 1'b0; sk[k] = '0; si[k] = '0; qi[k] = '0;
    end
  endtask

  // Reference transitions, written from the requirements.
  function automatic int m_cpu_next(int cur, bit wr, bit shr);
    if (wr) return 4;
    if (cur == 0) return shr ? 3 : 2;
    return cur;
  endfunction

  function automatic int m_cpu_req(int cur, bit wr);
    if (cur == 0) return wr ? 2 : 1;
    if (wr && (cur == 1 || cur == 3)) return 3;
    return 0;
  endfunction

  function automatic int m_snp_next(int cur, int k);
    if (cur == 0 || k == 3) return cur;
    return (k == 0) ? 1 : 0;
  endfunction

  function automatic int m_snp_flags(int cur, int k);
    int s, w, o;
    if (cur == 0 || k == 3) return 0;
    s = (cur == 4 || (cur == 3 && k != 2)) ? 1 : 0;
    w = (cur == 4) ? 1 : 0;
    o = (k == 0) ? 1 : 0;
    return s * 4 + w * 2 + o;
  endfunction

  task automatic do_reset();
    idle_all();
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    for (int k = 0; k < NC; k++)
      for (int l = 0; l < LINES; l++) mdl[k][l] = 0;
  endtask

  initial begin : watchdog
    #(20 * 150000);
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog all requirements actual=running expected=finished");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin : main
    do_reset();

    // R1: every line invalid after reset
    for (int l = 0; l < LINES; l++) begin
      qi[0] = 3'(l);
      #1 check(qs[0] == 3'd0, "R1 reset state", qs[0], 0);
    end

    // Directed vector walk on dut alone
    for (int v = 0; v < NV; v++) begin
      cv[0] = VECS[v].cv; cw[0] = VECS[v].cw; ci[0] = VECS[v].ci;
      sv[0] = VECS[v].sv; sk[0] = VECS[v].sk; si[0] = VECS[v].si;
      sh[0] = VECS[v].sh; qi[0] = VECS[v].qi;
      @(negedge clk);
      check({breq[0], sup[0], wbk[0], sho[0], rty[0]} ==
            {VECS[v].req, VECS[v].sup, VECS[v].wb, VECS[v].so, VECS[v].rt},
            $sformatf("R%0d outputs vec %0d", VECS[v].tag, v),
            {breq[0], sup[0], wbk[0], sho[0], rty[0]},
            {VECS[v].req, VECS[v].sup, VECS[v].wb, VECS[v].so, VECS[v].rt});
      @(posedge clk);
      #1 idle_all();
      qi[0] = VECS[v].qi;
      #1 check(qs[0] == VECS[v].qs, $sformatf("R%0d state vec %0d", VECS[v].tag, v),
               qs[0], VECS[v].qs);
    end

    // R1: reset in mid-run clears held lines
    do_reset();
    qi[0] = 3'd1;
    #1 check(qs[0] == 3'd0, "R1 mid-run reset", qs[0], 0);

    // R11: three controllers as one coherence group, random traffic
    for (int it = 0; it < ITERS; it++) begin
      int r, idx, cur, ereq, ek, any_sh;
      bit wr;
      int exp_fl [NC];
      int got_fl [NC];
      bit out_ok;
      int owners, valids, mods;
      r   = $urandom_range(0, NC - 1);
      idx = $urandom_range(0, 3);
      wr  = 1'($urandom_range(0, 1));
      cur = mdl[r][idx];
      any_sh = 0;
      for (int k = 0; k < NC; k++)
        if (k != r && mdl[k][idx] != 0) any_sh = 1;
      ereq = m_cpu_req(cur, wr);
      ek   = (ereq == 1) ? 0 : (ereq == 2) ? 1 : 2;
      cv[r] = 1'b1; cw[r] = wr; ci[r] = 3'(idx); sh[r] = 1'(any_sh);
      for (int k = 0; k < NC; k++) begin
        if (k != r) begin
          sv[k] = (ereq != 0); sk[k] = 2'(ek); si[k] = 3'(idx);
        end
      end
      @(negedge clk);
      out_ok = (breq[r] == 2'(ereq)) && !rty[r];
      for (int k = 0; k < NC; k++) begin
        exp_fl[k] = (k != r && ereq != 0) ? m_snp_flags(mdl[k][idx], ek) : 0;
        got_fl[k] = {sup[k], wbk[k], sho[k]};
        if (got_fl[k] != exp_fl[k]) out_ok = 1'b0;
      end
      check(out_ok, "R11 group outputs", {breq[r], 3'(got_fl[0]), 3'(got_fl[1]), 3'(got_fl[2])},
            {2'(ereq), 3'(exp_fl[0]), 3'(exp_fl[1]), 3'(exp_fl[2])});
      @(posedge clk);
      #1 idle_all();
      for (int k = 0; k < NC; k++) begin
        if (k == r) mdl[k][idx] = m_cpu_next(cur, wr, 1'(any_sh));
        else if (ereq != 0) mdl[k][idx] = m_snp_next(mdl[k][idx], ek);
        qi[k] = 3'(idx);
      end
      #1;
      owners = 0; valids = 0; mods = 0;
      for (int k = 0; k < NC; k++) begin
        check(qs[k] == 3'(mdl[k][idx]), "R11 group state", qs[k], mdl[k][idx]);
        if (qs[k] == 3'd2 || qs[k] == 3'd3 || qs[k] == 3'd4) owners++;
        if (qs[k] != 3'd0) valids++;
        if (qs[k] == 3'd4) mods++;
      end
      check(owners <= 1 && (mods == 0 || valids == 1), "R11 single owner",
            owners * 10 + valids, 10 + 1);
    end

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule